// File: doc/BRIEF.md
# Operand Effective Address Unit

This unit turns an addressing-mode code and the operand bytes that follow an 8-bit processor opcode into the 16-bit effective address of the access. It also returns the operand length in bytes, so the fetch logic knows how far to move the program counter. Direct modes are resolved arithmetically. The two pointer modes fetch a two-byte pointer from page zero through a synchronous read port with a latency of one cycle, and then finish the calculation.

Requests arrive on a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a pointer fetch is in progress. A request offered during that time is not taken, and its field values have no effect. The caller can keep `req_valid` high until it is accepted. The result is a plain one-cycle strobe with no back-pressure, so the consumer must capture it when it appears.

Mode codes on `req_mode`:
- 0 page zero
- 1 page zero + X
- 2 page zero + Y
- 3 absolute
- 4 absolute + X
- 5 absolute + Y
- 6 pointer pre-indexed by X
- 7 pointer post-indexed by Y
- 8 branch offset
- 9 immediate
- 10 to 15 unused

Top module: `opnd_addr_unit`

## Requirements
- R1: Mode 0 gives address {8'h00, lo} and length 1.
- R2: Modes 1 and 2 give {8'h00, (lo + X) mod 256} and {8'h00, (lo + Y) mod 256}. The sum never carries into the high byte. Length is 1.
- R3: Modes 3, 4 and 5 treat the operand as little-endian, with base {hi, lo}. They give base, base + X and base + Y modulo 65536, with full carry into the high byte. Length is 2.
- R4: Mode 6 first reads page-zero location p = (lo + X) mod 256, then location (p + 1) mod 256. The address is {second byte, first byte}. Length is 1.
- R5: Mode 7 first reads page-zero location lo, then location (lo + 1) mod 256. The address is {second, first} + Y modulo 65536, with full carry. Length is 1.
- R6: Mode 8 gives lo sign-extended to 16 bits, which is the signed branch displacement. Length is 1.
- R7: Mode 9 gives address 0 and length 1. Codes 10 to 15 give address 0 and length 0.
- R8: For a direct mode, `ea_valid` is high in the cycle after acceptance. For a pointer mode, the two reads are issued in the first and second cycles after acceptance, and `ea_valid` is high in the fourth cycle.
- R9: `req_ready` is low from the cycle after a pointer-mode acceptance through the third cycle after it. A request offered in that window is not taken and does not change the result.
- R10: After reset, `ea_valid` is 0, `req_ready` is 1 and `mem_rd_en` is 0. Each accepted request produces exactly one `ea_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can take a request |
| req_mode | input | 4 | Addressing-mode code |
| req_lo | input | 8 | First operand byte |
| req_hi | input | 8 | Second operand byte |
| req_x | input | 8 | X index value |
| req_y | input | 8 | Y index value |
| mem_rd_en | output | 1 | Pointer read strobe |
| mem_rd_addr | output | 16 | Pointer read address |
| mem_rd_data | input | 8 | Read data, one cycle after the strobe |
| ea_valid | output | 1 | Result strobe, one cycle |
| ea_addr | output | 16 | Effective address |
| ea_len | output | 2 | Operand bytes to skip |

## Verification
The assertions assume that the memory port returns data exactly one cycle after each read strobe, and that the caller holds the request fields stable in any cycle where it raises `req_valid`. The stimulus models the memory as a function of the read address, registered on the clock edge. It changes inputs only on falling edges. It draws modes, operands and indices at random from a fixed seed, including the unused codes. Directed cases add page-boundary wraps, carries into the high byte, a pointer base of $FF, and a request held pending through a pointer fetch.

// File: rtl/oau_pkg.sv
package oau_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned MODE_W = 4;
  localparam int unsigned LEN_W  = 2;

  localparam logic [MODE_W-1:0] MD_ZP   = 4'd0;
  localparam logic [MODE_W-1:0] MD_ZPX  = 4'd1;
  localparam logic [MODE_W-1:0] MD_ZPY  = 4'd2;
  localparam logic [MODE_W-1:0] MD_ABS  = 4'd3;
  localparam logic [MODE_W-1:0] MD_ABSX = 4'd4;
  localparam logic [MODE_W-1:0] MD_ABSY = 4'd5;
  localparam logic [MODE_W-1:0] MD_PREX = 4'd6;
  localparam logic [MODE_W-1:0] MD_POSY = 4'd7;
  localparam logic [MODE_W-1:0] MD_REL  = 4'd8;
  localparam logic [MODE_W-1:0] MD_IMM  = 4'd9;

  typedef enum logic [1:0] {
    PF_IDLE = 2'd0,
    PF_LO   = 2'd1,
    PF_HI   = 2'd2,
    PF_WAIT = 2'd3
  } pf_state_e;
endpackage

// File: rtl/oau_direct.sv
module oau_direct
  import oau_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [DW-1:0]     lo,
  input  logic [DW-1:0]     hi,
  input  logic [DW-1:0]     xi,
  input  logic [DW-1:0]     yi,
  output logic [2*DW-1:0]   addr,
  output logic [LEN_W-1:0]  len,
  output logic              is_ptr,
  output logic [DW-1:0]     ptr_base
);
  localparam int unsigned AW = 2 * DW;

  logic [DW-1:0] zp_x, zp_y;
  logic [AW-1:0] abs_base;

  assign zp_x     = lo + xi;
  assign zp_y     = lo + yi;
  assign abs_base = {hi, lo};

  always_comb begin
    addr     = '0;
    len      = 2'd0;
    is_ptr   = 1'b0;
    ptr_base = lo;
    case (mode)
      MD_ZP:   begin addr = {{DW{1'b0}}, lo};   len = 2'd1; end
      MD_ZPX:  begin addr = {{DW{1'b0}}, zp_x}; len = 2'd1; end
      MD_ZPY:  begin addr = {{DW{1'b0}}, zp_y}; len = 2'd1; end
      MD_ABS:  begin addr = abs_base;                      len = 2'd2; end
      MD_ABSX: begin addr = abs_base + {{DW{1'b0}}, xi};  len = 2'd2; end
      MD_ABSY: begin addr = abs_base + {{DW{1'b0}}, yi};  len = 2'd2; end
      MD_PREX: begin is_ptr = 1'b1; ptr_base = zp_x;      len = 2'd1; end
      MD_POSY: begin is_ptr = 1'b1; ptr_base = lo;        len = 2'd1; end
      MD_REL:  begin addr = {{DW{lo[DW-1]}}, lo};         len = 2'd1; end
      MD_IMM:  begin addr = '0;                           len = 2'd1; end
      default: begin addr = '0;                           len = 2'd0; end
    endcase
  end
endmodule

// File: rtl/oau_ptr_fetch.sv
module oau_ptr_fetch
  import oau_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            add_y,
  input  logic [DW-1:0]   base,
  input  logic [DW-1:0]   yi,
  output logic            busy,
  output logic            rd_en,
  output logic [2*DW-1:0] rd_addr,
  input  logic [DW-1:0]   rd_data,
  output logic            done,
  output logic [2*DW-1:0] addr
);
  localparam int unsigned AW = 2 * DW;

  pf_state_e     st;
  logic [DW-1:0] ptr_q, off_q, lo_q, ptr_nx;

  assign ptr_nx  = ptr_q + {{(DW-1){1'b0}}, 1'b1};
  assign busy    = (st != PF_IDLE);
  assign rd_en   = (st == PF_LO) || (st == PF_HI);
  assign rd_addr = {{DW{1'b0}}, (st == PF_HI) ? ptr_nx : ptr_q};
  assign done    = (st == PF_WAIT);
  assign addr    = {rd_data, lo_q} + {{DW{1'b0}}, off_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= PF_IDLE;
      ptr_q <= '0;
      off_q <= '0;
      lo_q  <= '0;
    end else begin
      case (st)
        PF_IDLE: if (start) begin
          ptr_q <= base;
          off_q <= add_y ? yi : '0;
          st    <= PF_LO;
        end
        PF_LO:   st <= PF_HI;
        PF_HI:   begin lo_q <= rd_data; st <= PF_WAIT; end
        default: st <= PF_IDLE;
      endcase
    end
  end

  // R4 R5: pointer reads stay in page zero
  a_r4_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr[AW-1:DW] == '0));
  // R5: the second read follows the first, wrapping inside the page
  a_r5_next_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PF_HI) |-> (rd_addr[DW-1:0] == $past(rd_addr[DW-1:0]) + {{(DW-1){1'b0}}, 1'b1}));
  // R10: completion lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
  import oau_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [DW-1:0]     req_lo,
  input  logic [DW-1:0]     req_hi,
  input  logic [DW-1:0]     req_x,
  input  logic [DW-1:0]     req_y,
  output logic              mem_rd_en,
  output logic [2*DW-1:0]   mem_rd_addr,
  input  logic [DW-1:0]     mem_rd_data,
  output logic              ea_valid,
  output logic [2*DW-1:0]   ea_addr,
  output logic [LEN_W-1:0]  ea_len
);
  localparam int unsigned AW = 2 * DW;

  logic [AW-1:0]    d_addr, f_addr;
  logic [LEN_W-1:0] d_len;
  logic             d_ptr, f_busy, f_done, accept;
  logic [DW-1:0]    d_base;

  oau_direct #(.DW(DW)) u_direct (
    .mode(req_mode), .lo(req_lo), .hi(req_hi), .xi(req_x), .yi(req_y),
    .addr(d_addr), .len(d_len), .is_ptr(d_ptr), .ptr_base(d_base)
  );

  assign req_ready = !f_busy;
  assign accept    = req_valid && req_ready;

  oau_ptr_fetch #(.DW(DW)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .start(accept && d_ptr), .add_y(req_mode == MD_POSY),
    .base(d_base), .yi(req_y),
    .busy(f_busy), .rd_en(mem_rd_en), .rd_addr(mem_rd_addr),
    .rd_data(mem_rd_data), .done(f_done), .addr(f_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_valid <= 1'b0;
      ea_addr  <= '0;
      ea_len   <= '0;
    end else begin
      ea_valid <= 1'b0;
      if (accept) ea_len <= d_len;
      if (accept && !d_ptr) begin
        ea_valid <= 1'b1;
        ea_addr  <= d_addr;
      end else if (f_done) begin
        ea_valid <= 1'b1;
        ea_addr  <= f_addr;
      end
    end
  end

  // R9: no request is taken while pointer reads are in flight
  a_r9_busy_reads: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !req_ready);
  // R9: a pointer-mode acceptance closes the handshake
  a_r9_ptr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && d_ptr) |=> !req_ready);
  // R8: a direct acceptance yields a result next cycle
  a_r8_direct_next: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !d_ptr) |=> ea_valid);
  // R3: no length beyond two bytes is reported
  a_r3_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |-> (ea_len != 2'd3));
endmodule

// File: tb/sim_opnd_addr_unit.sv
module sim_opnd_addr_unit;
  localparam int unsigned CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [3:0] req_mode = '0;
  logic [7:0] req_lo = '0, req_hi = '0, req_x = '0, req_y = '0;
  logic mem_rd_en, ea_valid;
  logic [15:0] mem_rd_addr, ea_addr;
  logic [7:0] mem_rd_data = '0;
  logic [1:0] ea_len;

  int checks = 0, failures = 0;
  int rd_total = 0;
  logic [15:0] rd_last = '0, rd_prev = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_addr_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_lo(req_lo), .req_hi(req_hi), .req_x(req_x), .req_y(req_y),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .ea_valid(ea_valid), .ea_addr(ea_addr), .ea_len(ea_len)
  );

  function automatic logic [7:0] membyte(input logic [15:0] a);
    if (a[15:8] != 8'h00) return 8'hEE;
    return a[7:0] * 8'd37 + 8'd11;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= membyte(mem_rd_addr);
      rd_prev     <= rd_last;
      rd_last     <= mem_rd_addr;
      rd_total    <= rd_total + 1;
    end
  end

  function automatic logic [15:0] exp_addr(input logic [3:0] m, input logic [7:0] lo, hi, x, y);
    logic [7:0] p;
    case (m)
      4'd0: return {8'h00, lo};
      4'd1: return {8'h00, 8'(lo + x)};
      4'd2: return {8'h00, 8'(lo + y)};
      4'd3: return {hi, lo};
      4'd4: return {hi, lo} + {8'h00, x};
      4'd5: return {hi, lo} + {8'h00, y};
      4'd6: begin p = lo + x;
        return {membyte({8'h00, 8'(p + 8'd1)}), membyte({8'h00, p})}; end
      4'd7: return {membyte({8'h00, 8'(lo + 8'd1)}), membyte({8'h00, lo})} + {8'h00, y};
      4'd8: return {{8{lo[7]}}, lo};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [1:0] exp_len(input logic [3:0] m);
    if (m == 4'd3 || m == 4'd4 || m == 4'd5) return 2'd2;
    if (m <= 4'd9) return 2'd1;
    return 2'd0;
  endfunction

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd0: return "R1";
      4'd1, 4'd2: return "R2";
      4'd3, 4'd4, 4'd5: return "R3";
      4'd6: return "R4";
      4'd7: return "R5";
      4'd8: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic run(input logic [3:0] m, input logic [7:0] lo, hi, x, y, input bit hold);
    bit ptr;
    int cnt, base_rd, lat;
    logic [7:0] p;
    ptr = (m == 4'd6 || m == 4'd7);
    lat = ptr ? 4 : 1;
    p = (m == 4'd6) ? 8'(lo + x) : lo;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_lo = lo; req_hi = hi; req_x = x; req_y = y;
    base_rd = rd_total;
    @(negedge clk);
    if (hold) begin
      req_mode = 4'd0; req_lo = 8'h55; req_x = 8'h11; req_y = 8'h22;
    end else req_valid = 1'b0;
    cnt = 1;
    while (!ea_valid && cnt < 8) begin
      if (ptr) chk(req_ready == 1'b0, "R9 ready low while fetching", req_ready, 0);
      if (cnt == 3) req_valid = 1'b0;
      @(negedge clk);
      cnt++;
    end
    req_valid = 1'b0;
    chk(ea_valid && cnt == lat, "R8 result latency", cnt, lat);
    chk(ea_addr == exp_addr(m, lo, hi, x, y), req_of(m), ea_addr, exp_addr(m, lo, hi, x, y));
    chk(ea_len == exp_len(m), {req_of(m), " length"}, ea_len, exp_len(m));
    if (ptr) begin
      chk(rd_total - base_rd == 2, "R4/R5 read count", rd_total - base_rd, 2);
      chk(rd_prev == {8'h00, p}, {req_of(m), " first read"}, rd_prev, {8'h00, p});
      chk(rd_last == {8'h00, 8'(p + 8'd1)}, {req_of(m), " second read"}, rd_last, {8'h00, 8'(p + 8'd1)});
    end
    @(negedge clk);
    chk(ea_valid == 1'b0, "R10 single pulse", ea_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #(CLK_PERIOD * 2 + 1);
    chk(ea_valid == 1'b0 && req_ready == 1'b1 && mem_rd_en == 1'b0, "R10 reset state",
        {ea_valid, req_ready, mem_rd_en}, 3'b010);
    @(negedge clk); rst_n = 1'b1;
    // directed corners
    run(4'd0, 8'hA7, 8'h33, 8'h00, 8'h00, 1'b0);   // R1
    run(4'd1, 8'hF0, 8'h12, 8'h20, 8'h00, 1'b0);   // R2 wrap
    run(4'd2, 8'hFF, 8'h12, 8'h00, 8'h01, 1'b0);   // R2 wrap
    run(4'd4, 8'hFF, 8'h12, 8'h01, 8'h00, 1'b0);   // R3 carry
    run(4'd5, 8'hFF, 8'hFF, 8'h00, 8'h01, 1'b0);   // R3 wrap to zero
    run(4'd3, 8'h34, 8'h12, 8'h99, 8'h99, 1'b0);   // R3
    run(4'd6, 8'hFE, 8'h00, 8'h01, 8'h00, 1'b0);   // R4 base FF
    run(4'd7, 8'hFF, 8'h00, 8'h00, 8'hF0, 1'b0);   // R5 base FF
    run(4'd7, 8'h10, 8'h00, 8'h00, 8'hFF, 1'b0);   // R5 carry
    run(4'd8, 8'h80, 8'h00, 8'h00, 8'h00, 1'b0);   // R6 negative
    run(4'd8, 8'h7F, 8'h00, 8'h00, 8'h00, 1'b0);   // R6 positive
    run(4'd9, 8'h42, 8'h00, 8'h00, 8'h00, 1'b0);   // R7
    run(4'd12, 8'h42, 8'h43, 8'h00, 8'h00, 1'b0);  // R7
    run(4'd6, 8'h20, 8'h00, 8'h05, 8'h00, 1'b1);   // R9 pending request ignored
    run(4'd7, 8'h30, 8'h00, 8'h00, 8'h07, 1'b1);   // R9
    for (int i = 0; i < 400; i++) begin
      run(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), 8'($urandom),
          8'($urandom), 1'($urandom_range(0, 1)));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule